// File: doc/BRIEF.md
# Centre-Aligned Dual-Slope PWM Timer

This block is a 16-bit up/down counter that drives two symmetric, centre-aligned pulse-width outputs. The counter climbs from zero to a ceiling, turns, falls back to zero, turns again and repeats. Each channel compares its active compare value with the count. A match on the rising slope moves the waveform one way and a match on the falling slope moves it the other way. The resulting pulse is centred on the bottom of the ramp.

The ceiling comes from one of five sources, picked by a mode input: three fixed widths, a buffered period value, or the active channel-A compare value. New compare and period values wait in a holding stage and become active only when the counter turns at the ceiling, so a ramp never uses a mix of old and new settings. A tick input gates every count step, so an external prescaler sets the rate. Sticky event flags record the bottom turn, the ceiling turn in period mode, and each channel's compare matches. A one-cycle pulse clears each flag.

Top module: `center_pwm_timer`

## Requirements
- R1: On each enabled tick the count moves one step. It rises from 0 to the ceiling, then falls back to 0. The ceiling value and the value 0 each last exactly one tick at the turn.
- R2: When tick is low, the count, the waveforms, the active values and the direction all hold their values.
- R3: The mode input selects the ceiling: 0 gives 0x00FF, 1 gives 0x01FF, 2 gives 0x03FF, 3 gives the active period, 4 gives the active channel-A compare, and 5 to 7 give 0x00FF.
- R4: period_in, cmp_a_in and cmp_b_in are copied into the active registers only on the tick where the counter turns at the ceiling. A change in the middle of a ramp does not alter that ramp.
- R5: With the output mode set to 2'b10 (non-inverting), a match on the rising slope drives the pin low and a match on the falling slope drives it high. After reset the waveform is high. Every output is registered, so it changes at the clock edge that samples the tick.
- R6: With the output mode set to 2'b11 (inverting), the pin is the complement of the non-inverting waveform.
- R7: With the output mode set to 2'b00 or 2'b01 (disconnected), the pin is 0. The internal waveform keeps following the matches, so reconnecting the pin shows the current state.
- R8: A match at count 0 always drives the waveform low and a match at the ceiling always drives it high. As a result, a compare value of 0 holds a non-inverting pin low for the whole period, and a compare value equal to the ceiling holds it high, with no pulse.
- R9: flag_bot is set on the tick where the falling count turns at 0.
- R10: flag_top is set on the ceiling-turn tick when mode is 3. flag_a and flag_b are set on every tick where the count equals that channel's active compare value.
- R11: Each flag stays set until its clear input is high for a cycle. If a set and a clear arrive in the same cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Count enable |
| mode | input | 3 | Ceiling source select |
| period_in | input | 16 | Buffered period value |
| cmp_a_in | input | 16 | Buffered channel-A compare value |
| cmp_b_in | input | 16 | Buffered channel-B compare value |
| outmode_a | input | 2 | Channel-A pin mode: bit 1 connects the pin, bit 0 inverts it |
| outmode_b | input | 2 | Channel-B pin mode |
| clr_bot | input | 1 | Clear pulse for flag_bot |
| clr_top | input | 1 | Clear pulse for flag_top |
| clr_a | input | 1 | Clear pulse for flag_a |
| clr_b | input | 1 | Clear pulse for flag_b |
| cnt | output | 16 | Current count |
| pwm_a | output | 1 | Channel-A pin |
| pwm_b | output | 1 | Channel-B pin |
| flag_bot | output | 1 | Bottom-turn flag |
| flag_top | output | 1 | Ceiling-turn flag (period mode) |
| flag_a | output | 1 | Channel-A match flag |
| flag_b | output | 1 | Channel-B match flag |

## Verification
The hardest case to reach from the ports is a buffered write that lands in the middle of a rising ramp and then must not move the ceiling until the next turn. The stimulus waits until it sees the count step from 1 to 2, which can only happen on the rising slope. It then lowers period_in and checks that the old ceiling is still reached before the new one takes effect. Random segments vary the mode, the tick density, the output modes and the clear pulses, and they pick compare values of 0, of the ceiling, and just above it. This drives the matches at the turns and the clear-against-set collisions.

// File: rtl/center_pwm_pkg.sv
`timescale 1ns/1ps
package center_pwm_pkg;
  // ceiling source codes; the order is decoded by the counter
  localparam logic [2:0] SEL_FIX8   = 3'd0;
  localparam logic [2:0] SEL_FIX9   = 3'd1;
  localparam logic [2:0] SEL_FIX10  = 3'd2;
  localparam logic [2:0] SEL_PERIOD = 3'd3;
  localparam logic [2:0] SEL_CMPA   = 3'd4;

  // pin mode: bit 1 connects, bit 0 inverts
  function automatic logic pin_drive(input logic [1:0] om, input logic wave);
    return om[1] ? (wave ^ om[0]) : 1'b0;
  endfunction
endpackage

// File: rtl/pwm_ramp_counter.sv
`timescale 1ns/1ps
module pwm_ramp_counter
  import center_pwm_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic [2:0]       mode,
  input  logic [CNT_W-1:0] period_in,
  input  logic [CNT_W-1:0] cmp_a_act,
  output logic [CNT_W-1:0] cnt,
  output logic             dir_up,
  output logic [CNT_W-1:0] ceil_val,
  output logic             turn_top,
  output logic             turn_bot
);
  localparam logic [CNT_W-1:0] CEIL8  = CNT_W'(32'd255);
  localparam logic [CNT_W-1:0] CEIL9  = CNT_W'(32'd511);
  localparam logic [CNT_W-1:0] CEIL10 = CNT_W'(32'd1023);
  localparam logic [CNT_W-1:0] ONE    = CNT_W'(32'd1);

  logic [CNT_W-1:0] period_act;

  always_comb begin
    case (mode)
      SEL_FIX9:   ceil_val = CEIL9;
      SEL_FIX10:  ceil_val = CEIL10;
      SEL_PERIOD: ceil_val = period_act;
      SEL_CMPA:   ceil_val = cmp_a_act;
      default:    ceil_val = CEIL8;
    endcase
  end

  assign turn_top = tick & dir_up & (cnt >= ceil_val);
  assign turn_bot = tick & ~dir_up & (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt        <= '0;
      dir_up     <= 1'b1;
      period_act <= '0;
    end else if (tick) begin
      if (dir_up) begin
        if (cnt >= ceil_val) begin
          dir_up <= 1'b0;
          cnt    <= (cnt == '0) ? cnt : cnt - ONE;
        end else begin
          cnt <= cnt + ONE;
        end
      end else begin
        if (cnt == '0) begin
          dir_up <= 1'b1;
          cnt    <= cnt + ONE;
        end else begin
          cnt <= cnt - ONE;
        end
      end
      if (turn_top) period_act <= period_in;
    end
  end
endmodule

// File: rtl/pwm_channel.sv
`timescale 1ns/1ps
module pwm_channel
  import center_pwm_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             load,
  input  logic [CNT_W-1:0] cnt,
  input  logic             dir_up,
  input  logic [CNT_W-1:0] ceil_val,
  input  logic [CNT_W-1:0] cmp_in,
  input  logic [1:0]       outmode,
  output logic [CNT_W-1:0] cmp_act,
  output logic             match,
  output logic             pin
);
  logic wave, wave_n;

  assign match = tick & (cnt == cmp_act);

  always_comb begin
    wave_n = wave;
    if (match) begin
      if (cnt == '0)            wave_n = 1'b0;
      else if (cnt >= ceil_val) wave_n = 1'b1;
      else                      wave_n = ~dir_up;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmp_act <= '0;
      wave    <= 1'b1;
      pin     <= 1'b0;
    end else begin
      if (load) cmp_act <= cmp_in;
      wave <= wave_n;
      pin  <= pin_drive(outmode, wave_n);
    end
  end
endmodule

// File: rtl/center_pwm_timer.sv
`timescale 1ns/1ps
module center_pwm_timer
  import center_pwm_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic [2:0]       mode,
  input  logic [CNT_W-1:0] period_in,
  input  logic [CNT_W-1:0] cmp_a_in,
  input  logic [CNT_W-1:0] cmp_b_in,
  input  logic [1:0]       outmode_a,
  input  logic [1:0]       outmode_b,
  input  logic             clr_bot,
  input  logic             clr_top,
  input  logic             clr_a,
  input  logic             clr_b,
  output logic [CNT_W-1:0] cnt,
  output logic             pwm_a,
  output logic             pwm_b,
  output logic             flag_bot,
  output logic             flag_top,
  output logic             flag_a,
  output logic             flag_b
);
  localparam int NUM_CH = 2;

  logic             dir_up, turn_top, turn_bot;
  logic [CNT_W-1:0] ceil_val;
  logic [CNT_W-1:0] cmp_in_v  [NUM_CH];
  logic [CNT_W-1:0] cmp_act_v [NUM_CH];
  logic [1:0]       om_v      [NUM_CH];
  logic [NUM_CH-1:0] match_v, pin_v, clr_v, flag_v;

  assign cmp_in_v[0] = cmp_a_in;
  assign cmp_in_v[1] = cmp_b_in;
  assign om_v[0]     = outmode_a;
  assign om_v[1]     = outmode_b;
  assign clr_v       = {clr_b, clr_a};

  pwm_ramp_counter #(.CNT_W(CNT_W)) u_ramp (
    .clk(clk), .rst(rst), .tick(tick), .mode(mode),
    .period_in(period_in), .cmp_a_act(cmp_act_v[0]),
    .cnt(cnt), .dir_up(dir_up), .ceil_val(ceil_val),
    .turn_top(turn_top), .turn_bot(turn_bot)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    pwm_channel #(.CNT_W(CNT_W)) u_ch (
      .clk(clk), .rst(rst), .tick(tick), .load(turn_top),
      .cnt(cnt), .dir_up(dir_up), .ceil_val(ceil_val),
      .cmp_in(cmp_in_v[g]), .outmode(om_v[g]),
      .cmp_act(cmp_act_v[g]), .match(match_v[g]), .pin(pin_v[g])
    );

    always_ff @(posedge clk) begin
      if (rst) flag_v[g] <= 1'b0;
      else     flag_v[g] <= match_v[g] | (flag_v[g] & ~clr_v[g]);
    end
  end

  assign pwm_a  = pin_v[0];
  assign pwm_b  = pin_v[1];
  assign flag_a = flag_v[0];
  assign flag_b = flag_v[1];

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_bot <= 1'b0;
      flag_top <= 1'b0;
    end else begin
      flag_bot <= turn_bot | (flag_bot & ~clr_bot);
      flag_top <= (turn_top & (mode == SEL_PERIOD)) | (flag_top & ~clr_top);
    end
  end
endmodule

// File: rtl/center_pwm_timer_chk.sv
`timescale 1ns/1ps
module center_pwm_timer_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             tick,
  input logic [1:0]       outmode_a,
  input logic [1:0]       outmode_b,
  input logic             clr_bot,
  input logic             clr_a,
  input logic [CNT_W-1:0] cnt,
  input logic             pwm_a,
  input logic             pwm_b,
  input logic             flag_bot,
  input logic             flag_a
);
  // R2
  hold_cnt_chk: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(cnt));

  // R1
  step_cnt_chk: assert property (@(posedge clk) disable iff (rst)
    tick |=> (cnt == $past(cnt) + 1'b1) || (cnt == $past(cnt) - 1'b1) ||
             (cnt == '0 && $past(cnt) == '0));

  // R7
  off_a_chk: assert property (@(posedge clk) disable iff (rst)
    !outmode_a[1] |=> !pwm_a);

  // R7
  off_b_chk: assert property (@(posedge clk) disable iff (rst)
    !outmode_b[1] |=> !pwm_b);

  // R9
  bot_flag_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(flag_bot) |-> $past(cnt) == '0);

  // R11
  sticky_bot_chk: assert property (@(posedge clk) disable iff (rst)
    (flag_bot && !clr_bot) |=> flag_bot);

  // R11
  sticky_a_chk: assert property (@(posedge clk) disable iff (rst)
    (flag_a && !clr_a) |=> flag_a);
endmodule

bind center_pwm_timer center_pwm_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .tick(tick), .outmode_a(outmode_a),
  .outmode_b(outmode_b), .clr_bot(clr_bot), .clr_a(clr_a), .cnt(cnt),
  .pwm_a(pwm_a), .pwm_b(pwm_b), .flag_bot(flag_bot), .flag_a(flag_a)
);

// File: tb/center_pwm_timer_test.sv
`timescale 1ns/1ps
module center_pwm_timer_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick = 1'b0;
  logic [2:0] mode = 3'd3;
  logic [15:0] period_in = 16'd20, cmp_a_in = 16'd0, cmp_b_in = 16'd20;
  logic [1:0] outmode_a = 2'b10, outmode_b = 2'b10;
  logic clr_bot = 0, clr_top = 0, clr_a = 0, clr_b = 0;
  logic [15:0] cnt;
  logic pwm_a, pwm_b, flag_bot, flag_top, flag_a, flag_b;
  int total = 0, bad = 0;

  always #5 clk = ~clk;

  center_pwm_timer uut (
    .clk(clk), .rst(rst), .tick(tick), .mode(mode), .period_in(period_in),
    .cmp_a_in(cmp_a_in), .cmp_b_in(cmp_b_in), .outmode_a(outmode_a),
    .outmode_b(outmode_b), .clr_bot(clr_bot), .clr_top(clr_top),
    .clr_a(clr_a), .clr_b(clr_b), .cnt(cnt), .pwm_a(pwm_a), .pwm_b(pwm_b),
    .flag_bot(flag_bot), .flag_top(flag_top), .flag_a(flag_a), .flag_b(flag_b)
  );

  function automatic logic [15:0] exp_ceil(logic [2:0] md, logic [15:0] per, logic [15:0] ca);
    case (md)
      3'd1: return 16'h01FF;
      3'd2: return 16'h03FF;
      3'd3: return per;
      3'd4: return ca;
      default: return 16'h00FF;
    endcase
  endfunction

  // reference state, as seen after each rising edge
  logic [15:0] m_cnt, m_per;
  logic [15:0] m_cmp [2];
  logic        m_up, m_fbot, m_ftop, m_fa, m_fb, l_tick;
  logic [1:0]  m_wave, m_pin, l_om [2];
  logic [3:0]  l_clr;

  always @(posedge clk) begin : ref_model
    logic [15:0] t;
    logic att, atb;
    logic [1:0] mt, nw;
    if (rst) begin
      m_cnt = 0; m_per = 0; m_cmp[0] = 0; m_cmp[1] = 0; m_up = 1;
      m_wave = 2'b11; m_pin = 0; m_fbot = 0; m_ftop = 0; m_fa = 0; m_fb = 0;
      l_tick = 1; l_om[0] = 2'b10; l_om[1] = 2'b10; l_clr = 0;
    end else begin
      t   = exp_ceil(mode, m_per, m_cmp[0]);
      att = tick && m_up && (m_cnt >= t);
      atb = tick && !m_up && (m_cnt == 0);
      nw = m_wave; mt = 0;
      for (int c = 0; c < 2; c++)
        if (tick && m_cnt == m_cmp[c]) begin
          mt[c] = 1;
          nw[c] = (m_cnt == 0) ? 1'b0 : (m_cnt >= t) ? 1'b1 : !m_up;
        end
      m_fa   = mt[0] | (m_fa & !clr_a);
      m_fb   = mt[1] | (m_fb & !clr_b);
      m_ftop = (att && mode == 3'd3) | (m_ftop & !clr_top);
      m_fbot = atb | (m_fbot & !clr_bot);
      if (att) begin m_per = period_in; m_cmp[0] = cmp_a_in; m_cmp[1] = cmp_b_in; end
      if (tick) begin
        if (m_up) begin
          if (m_cnt >= t) begin m_up = 0; if (m_cnt != 0) m_cnt = m_cnt - 1; end
          else m_cnt = m_cnt + 1;
        end else begin
          if (m_cnt == 0) begin m_up = 1; m_cnt = 1; end
          else m_cnt = m_cnt - 1;
        end
      end
      m_wave = nw;
      m_pin[0] = outmode_a[1] ? (nw[0] ^ outmode_a[0]) : 1'b0;
      m_pin[1] = outmode_b[1] ? (nw[1] ^ outmode_b[0]) : 1'b0;
      l_tick = tick; l_om[0] = outmode_a; l_om[1] = outmode_b;
      l_clr = {clr_b, clr_a, clr_top, clr_bot};
    end
  end

  task automatic chk(input string tag, input string what, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s %s got=%0h exp=%0h", tag, what, got, exp);
    end
  endtask

  function automatic string pin_tag(logic [1:0] om);
    return !om[1] ? "R7" : om[0] ? "R6" : "R5";
  endfunction

  task automatic compare_all();
    chk(l_tick ? "R1" : "R2", "cnt", cnt, m_cnt);
    chk(pin_tag(l_om[0]), "pwm_a", pwm_a, m_pin[0]);
    chk(pin_tag(l_om[1]), "pwm_b", pwm_b, m_pin[1]);
    chk(l_clr[0] ? "R11" : "R9", "flag_bot", flag_bot, m_fbot);
    chk(l_clr[1] ? "R11" : "R10", "flag_top", flag_top, m_ftop);
    chk(l_clr[2] ? "R11" : "R10", "flag_a", flag_a, m_fa);
    chk(l_clr[3] ? "R11" : "R10", "flag_b", flag_b, m_fb);
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      compare_all();
    end
  endtask

  task automatic max_over(input int n, output logic [15:0] mx);
    mx = 0;
    for (int i = 0; i < n; i++) begin
      cyc(1);
      if (cnt > mx) mx = cnt;
    end
  endtask

  initial begin : watchdog
    #2_000_000;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : stim
    int unsigned seed;
    logic [15:0] mx, held;
    int lo_a, hi_b;
    seed = $urandom(32'd5150);
    repeat (3) @(negedge clk);
    chk("R1", "reset cnt", cnt, 0);
    chk("R5", "reset pins", {pwm_a, pwm_b}, 0);
    chk("R9", "reset flags", {flag_bot, flag_top, flag_a, flag_b}, 0);
    rst = 0; tick = 1;

    // R8: compare 0 keeps A low, compare == ceiling keeps B high
    cyc(100);
    lo_a = 0; hi_b = 0;
    for (int i = 0; i < 42; i++) begin
      cyc(1);
      if (pwm_a) lo_a++;
      if (!pwm_b) hi_b++;
    end
    chk("R8", "A high cycles at cmp 0", lo_a, 0);
    chk("R8", "B low cycles at cmp top", hi_b, 0);

    // R2: no tick, nothing moves
    tick = 0; held = cnt;
    cyc(20);
    chk("R2", "cnt held without tick", cnt, held);
    tick = 1;

    // R3: fixed 8-bit ceiling
    mode = 3'd0;
    cyc(600);
    max_over(520, mx);
    chk("R3", "8-bit ceiling", mx, 16'h00FF);
    // R3: ceiling from channel-A compare
    cmp_a_in = 16'd6; mode = 3'd4;
    cyc(600);
    max_over(100, mx);
    chk("R3", "cmp-A ceiling", mx, 16'd6);

    // R4: period change mid-ramp waits for the turn
    mode = 3'd3; period_in = 16'd12; cmp_a_in = 16'd3; cmp_b_in = 16'd9;
    cyc(100);
    held = cnt;
    for (int i = 0; i < 200; i++) begin
      cyc(1);
      if (held == 16'd1 && cnt == 16'd2) break;
      held = cnt;
    end
    period_in = 16'd4;
    max_over(12, mx);
    chk("R4", "old ceiling kept", mx, 16'd12);
    cyc(30);
    max_over(30, mx);
    chk("R4", "new ceiling used", mx, 16'd4);

    // random segments checked against the reference state
    for (int s = 0; s < 30; s++) begin
      int dens;
      logic [15:0] p;
      mode = 3'($urandom % 8);
      p = 16'(3 + $urandom % 38);
      period_in = p;
      dens = $urandom % 3;
      case ($urandom % 4)
        0: cmp_a_in = 0;
        1: cmp_a_in = p;
        2: cmp_a_in = p + 1;
        default: cmp_a_in = 16'($urandom % (p + 1));
      endcase
      if (mode == 3'd4 && cmp_a_in < 3) cmp_a_in = 16'd3;
      case ($urandom % 4)
        0: cmp_b_in = 0;
        1: cmp_b_in = p;
        default: cmp_b_in = 16'($urandom % 300);
      endcase
      for (int i = 0; i < 700; i++) begin
        cyc(1);
        tick = (dens == 0) ? 1'b1 : (($urandom % (dens * 2)) == 0);
        if ($urandom % 50 == 0) outmode_a = 2'($urandom);
        if ($urandom % 50 == 0) outmode_b = 2'($urandom);
        clr_bot = ($urandom % 12 == 0);
        clr_top = ($urandom % 12 == 0);
        clr_a   = ($urandom % 12 == 0);
        clr_b   = ($urandom % 12 == 0);
      end
    end
    cyc(2);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule